// File: doc/BRIEF.md
# Double-Buffered Serial Data Register for a Two-Wire Bus Controller

This block is the byte datapath of a two-wire (I2C) bus controller. Software writes a byte into a holding buffer. A separate shift register puts that byte out on the data line one bit at a time, most significant bit first, and collects incoming bits into its least significant end. The protocol sequencer lives outside this block. It supplies the bus-busy level, strobes for an interrupt-flag clear, a repeated-start request and a slave address match, and two bit-phase enables. The drive enable fires in the clock-low phase and the sample enable fires in the clock-high phase.

The holding buffer decouples software from the transfer on the wire. A write made while the bus is busy leaves the byte in flight untouched. That byte moves into the shift register only at one of the allowed load points. While the bus is idle, a write goes straight through, so the first address byte is in place before a start condition. Reads return the live shift register, so received data is meaningful once the byte-complete pulse has fired.

Top module: `i2c_dbuf_shreg`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00, `sda_out` is 1 (line released) and `byte_done` is 0.
- R2: With `bus_busy`=0, a write (`wr_en`=1) places `wr_data` in the shift register, and `rd_data` shows it on the next cycle.
- R3: With `bus_busy`=1, a write with no load event that cycle leaves `rd_data` and `sda_out` unchanged.
- R4: With `bus_busy`=1 and `slave_mode`=0, an `int_clr` strobe copies the holding buffer into the shift register.
- R5: With `bus_busy`=1 and `slave_mode`=0, an `rstart_req` strobe copies the holding buffer into the shift register.
- R6: With `bus_busy`=1 and `slave_mode`=1, `int_clr` and `rstart_req` load nothing until `addr_match` has pulsed. The `addr_match` pulse itself loads the holding buffer, and later `int_clr` or `rstart_req` strobes load it too. The matched state clears whenever `bus_busy` is 0.
- R7: A write in the same cycle as a load event loads the newly written byte.
- R8: A `sample_en` pulse shifts the register left by one bit and places `sda_in` in bit 0.
- R9: A `drive_en` pulse sets `sda_out` to bit 7 of the shift register as it stood before that edge. A byte therefore leaves most significant bit first.
- R10: While `bus_busy`=1, `byte_done` is high for exactly the one cycle after the eighth `sample_en` counted since the last load or since the bus went busy.
- R11: When a load event and `sample_en` fall in the same cycle, the load wins and the bit count restarts at zero.
- R12: Outside load events and `sample_en`, the shift register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write byte |
| bus_busy | input | 1 | Bus occupied between start and stop |
| slave_mode | input | 1 | Controller is acting as a slave |
| int_clr | input | 1 | Transfer-complete flag cleared by software |
| rstart_req | input | 1 | Software asked for a repeated start |
| addr_match | input | 1 | Own slave address recognised |
| drive_en | input | 1 | Clock-low phase: present the next bit |
| sample_en | input | 1 | Clock-high phase: capture the line |
| sda_in | input | 1 | Sampled data line level |
| sda_out | output | 1 | Data bit to drive (1 = release) |
| rd_data | output | 8 | Live shift register contents |
| byte_done | output | 1 | One-cycle pulse after eight samples |

## Verification
The shift register can be asked to reload and to shift in the same cycle. The bench provokes this by asserting `int_clr` together with `sample_en`, and it judges the result by reading the loaded byte untouched and then counting a full eight further samples before `byte_done` appears. A second overlap is a software write landing on the same edge as a load strobe, and there the freshly written byte must win over the older buffer contents. Both cases, and every other cycle, are compared against a behavioural model held in the bench.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int DSR_W = 8;

    typedef logic [DSR_W-1:0] dsr_word_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_WRITE = 2'd1,
        SRC_HOLD  = 2'd2
    } load_src_e;

    typedef struct packed {
        logic      en;
        load_src_e src;
        dsr_word_t val;
    } load_req_t;

    function automatic dsr_word_t shift_in(input dsr_word_t cur, input logic b);
        return {cur[DSR_W-2:0], b};
    endfunction
endpackage

// File: rtl/dsr_hold.sv
module dsr_hold
    import dsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  dsr_word_t wr_data,
    output dsr_word_t hold_q
);
    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (wr_en) hold_q <= wr_data;
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> hold_q == $past(hold_q)); // R3
endmodule

// File: rtl/dsr_load_ctrl.sv
module dsr_load_ctrl
    import dsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  dsr_word_t wr_data,
    input  dsr_word_t hold_q,
    input  logic      bus_busy,
    input  logic      slave_mode,
    input  logic      int_clr,
    input  logic      rstart_req,
    input  logic      addr_match,
    output load_req_t req
);
    logic matched_q;
    logic busy_ev;

    always_ff @(posedge clk) begin
        if (rst || !bus_busy)           matched_q <= 1'b0;
        else if (slave_mode && addr_match) matched_q <= 1'b1;
    end

    always_comb begin
        if (slave_mode)
            busy_ev = addr_match || (matched_q && (int_clr || rstart_req));
        else
            busy_ev = int_clr || rstart_req;

        req = '{en: 1'b0, src: SRC_NONE, val: '0};
        if (!bus_busy) begin
            if (wr_en) req = '{en: 1'b1, src: SRC_WRITE, val: wr_data};
        end else if (busy_ev) begin
            if (wr_en) req = '{en: 1'b1, src: SRC_WRITE, val: wr_data};
            else       req = '{en: 1'b1, src: SRC_HOLD,  val: hold_q};
        end
    end

    AST_IDLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!bus_busy && wr_en) |-> (req.en && req.val == wr_data)); // R2
    AST_SLAVE_GATED: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && slave_mode && !matched_q && !addr_match) |-> !req.en); // R6
    AST_FWD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req.en && wr_en) |-> req.val == wr_data); // R7
endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter
    import dsr_pkg::*;
#(
    parameter int W = DSR_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_busy,
    input  load_req_t req,
    input  logic      drive_en,
    input  logic      sample_en,
    input  logic      sda_in,
    output dsr_word_t sr_q,
    output logic      sda_q,
    output logic      done_q
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (drive_en) sda_q <= sr_q[W-1];
            done_q <= 1'b0;
            if (req.en) begin
                sr_q  <= req.val;
                cnt_q <= '0;
            end else if (sample_en) begin
                sr_q <= shift_in(sr_q, sda_in);
                if (!bus_busy) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (!bus_busy) begin
                cnt_q <= '0;
            end
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        req.en |=> sr_q == $past(req.val)); // R11
    AST_SAMPLE_LSB: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !req.en) |=> sr_q[0] == $past(sda_in)); // R8
    AST_SR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !req.en) |=> $stable(sr_q)); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10
    AST_DONE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(sample_en && !req.en)); // R10
endmodule

// File: rtl/i2c_dbuf_shreg.sv
module i2c_dbuf_shreg
    import dsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bus_busy,
    input  logic       slave_mode,
    input  logic       int_clr,
    input  logic       rstart_req,
    input  logic       addr_match,
    input  logic       drive_en,
    input  logic       sample_en,
    input  logic       sda_in,
    output logic       sda_out,
    output logic [7:0] rd_data,
    output logic       byte_done
);
    dsr_word_t hold_q;
    dsr_word_t sr_q;
    load_req_t req;

    dsr_hold u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .hold_q(hold_q)
    );

    dsr_load_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .hold_q(hold_q),
        .bus_busy(bus_busy), .slave_mode(slave_mode), .int_clr(int_clr),
        .rstart_req(rstart_req), .addr_match(addr_match), .req(req)
    );

    dsr_shifter #(.W(DSR_W)) u_shift (
        .clk(clk), .rst(rst), .bus_busy(bus_busy), .req(req),
        .drive_en(drive_en), .sample_en(sample_en), .sda_in(sda_in),
        .sr_q(sr_q), .sda_q(sda_out), .done_q(byte_done)
    );

    assign rd_data = sr_q;

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        drive_en |=> sda_out == $past(rd_data[7])); // R9
    AST_BUSY_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !int_clr && !rstart_req && !addr_match && !sample_en)
        |=> $stable(rd_data)); // R3
endmodule

// File: tb/i2c_dbuf_shreg_bench.sv
module i2c_dbuf_shreg_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, bus_busy = 0, slave_mode = 0, int_clr = 0;
    logic rstart_req = 0, addr_match = 0, drive_en = 0, sample_en = 0, sda_in = 0;
    logic [7:0] wr_data = '0;
    logic sda_out, byte_done;
    logic [7:0] rd_data;

    int checks = 0, fails = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference state
    logic [7:0] m_sr = 0, m_hold = 0;
    logic m_sda = 1, m_done = 0, m_match = 0;
    int m_cnt = 0;
    bit tx_bits[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_dbuf_shreg u_i2c_dbuf_shreg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .bus_busy(bus_busy),
        .slave_mode(slave_mode), .int_clr(int_clr), .rstart_req(rstart_req),
        .addr_match(addr_match), .drive_en(drive_en), .sample_en(sample_en),
        .sda_in(sda_in), .sda_out(sda_out), .rd_data(rd_data), .byte_done(byte_done)
    );

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic model_step();
        bit ld;
        logic [7:0] lv;
        if (rst) begin
            m_sr = 0; m_hold = 0; m_sda = 1; m_done = 0; m_match = 0; m_cnt = 0;
            return;
        end
        if (!bus_busy) ld = wr_en;
        else if (slave_mode) ld = addr_match || (m_match && (int_clr || rstart_req));
        else ld = int_clr || rstart_req;
        lv = wr_en ? wr_data : m_hold;
        if (drive_en) m_sda = m_sr[7];
        m_done = 0;
        if (ld) begin
            m_sr = lv; m_cnt = 0;
        end else if (sample_en) begin
            m_sr = {m_sr[6:0], sda_in};
            if (!bus_busy) m_cnt = 0;
            else if (m_cnt == 7) begin m_cnt = 0; m_done = 1; end
            else m_cnt++;
        end else if (!bus_busy) m_cnt = 0;
        if (!bus_busy) m_match = 0;
        else if (slave_mode && addr_match) m_match = 1;
        if (wr_en) m_hold = wr_data;
    endtask

    // one clock: model advances at the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " rd_data"}, rd_data, m_sr);
        chk({tag, " sda_out"}, sda_out, m_sda);
        chk({tag, " byte_done"}, byte_done, m_done);
        wr_en = 0; int_clr = 0; rstart_req = 0; addr_match = 0;
        drive_en = 0; sample_en = 0;
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1; wr_data = d; tick();
    endtask

    // transmit a byte on the wire with the line echoing the driven bit
    task automatic send_byte();
        tx_bits.delete();
        for (int i = 0; i < 8; i++) begin
            drive_en = 1; tick();
            tx_bits.push_back(sda_out);
            sda_in = sda_out; sample_en = 1; tick();
        end
    endtask

    task automatic recv_byte(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_in = b[7-i]; sample_en = 1; tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v;
        @(negedge clk); @(negedge clk);
        rst = 1; tick(); rst = 0;
        tag = "R1";
        chk("R1 reset rd_data", rd_data, 8'h00);
        chk("R1 reset sda_out", sda_out, 1);
        chk("R1 reset byte_done", byte_done, 0);

        tag = "R2"; write(8'hA5);
        chk("R2 idle write reaches shift register", rd_data, 8'hA5);

        tag = "R3"; bus_busy = 1; write(8'h3C);
        tick(); tick();
        chk("R3 busy write leaves transfer", rd_data, 8'hA5);

        tag = "R9"; send_byte();
        v = 0;
        foreach (tx_bits[i]) v = (v << 1) | int'(tx_bits[i]);
        chk("R9 bits left MSB first", v, 8'hA5);
        chk("R10 byte_done after eighth sample", byte_done, 1);
        tick();
        chk("R10 byte_done single cycle", byte_done, 0);

        tag = "R4"; int_clr = 1; tick();
        chk("R4 int_clr loads buffer", rd_data, 8'h3C);

        tag = "R5"; write(8'h81); rstart_req = 1; tick();
        chk("R5 repeated start loads buffer", rd_data, 8'h81);

        tag = "R8"; recv_byte(8'h5E, 8);
        chk("R8 received byte", rd_data, 8'h5E);
        chk("R10 receive completion", byte_done, 1);

        tag = "R11"; write(8'h77);
        int_clr = 1; sample_en = 1; sda_in = 1; tick();
        chk("R11 load beats sample", rd_data, 8'h77);
        recv_byte(8'h00, 7);
        chk("R11 count restarted, no done at 7", byte_done, 0);
        recv_byte(8'h00, 1);
        chk("R11 done at 8 after load", byte_done, 1);

        tag = "R7"; write(8'hF0);
        wr_en = 1; wr_data = 8'h12; int_clr = 1; tick();
        chk("R7 same-cycle write forwarded", rd_data, 8'h12);

        tag = "R6"; bus_busy = 0; tick();
        slave_mode = 1; bus_busy = 1; write(8'h44);
        int_clr = 1; tick();
        chk("R6 int_clr ignored before match", rd_data, 8'h12);
        rstart_req = 1; tick();
        chk("R6 rstart ignored before match", rd_data, 8'h12);
        addr_match = 1; tick();
        chk("R6 address match loads", rd_data, 8'h44);
        write(8'h55); int_clr = 1; tick();
        chk("R6 int_clr after match loads", rd_data, 8'h55);
        bus_busy = 0; tick(); bus_busy = 1;
        write(8'h66); int_clr = 1; tick();
        chk("R6 match cleared by idle bus", rd_data, 8'h55);

        tag = "R12"; repeat (4) tick();
        chk("R12 register holds", rd_data, 8'h55);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule